// File: doc/BRIEF.md
# Set-on-Write Interrupt Status Controller

This block holds the event status of a MAC, the enable mask that goes with it and a small command word shared by two agents. A local sequencer, which has a 16-bit data path, reports events by writing ones into either half of the 32-bit status. It cannot clear status bits. The host, which has a 32-bit data path, reads the whole status and clears the bits it has handled by writing ones to them.

The interrupt line tells the host that something new has arrived. It is raised only when a sequencer write turns on a bit that was clear and is enabled in the mask. A plain status read ignores the mask, so a bit that is disabled in the mask still accumulates in status but raises no interrupt. The line is a level held by a pending flag, which the host clears by writing to an acknowledge location.

The command word works in the opposite direction to status. The host posts requests by setting bits, for example "template 0 valid" in bit 0 and "template 1 valid" in bit 1. The sequencer retires requests by writing a mask of the bits to turn off. The host leaves the resource behind a command bit alone until that bit reads back as zero.

Top module: `mac_event_irq`

## Requirements
- R1: After a synchronous active-low reset, status, mask, command and the interrupt line are all zero.
- R2: A sequencer write to location 0 ORs its 16 data bits into status bits 15:0. A write to location 1 ORs them into status bits 31:16. Such a write never clears a status bit. Sequencer reads of locations 0 and 1 return the matching half.
- R3: Sequencer writes to locations 2 and 3 replace mask bits 15:0 and 31:16, and reads of those locations return the matching half. A host write to location 1 replaces the whole mask, and a host read of location 1 returns it. When the host and the sequencer write the mask in the same cycle, the host value is taken.
- R4: A sequencer status write raises the interrupt on the following cycle if at least one written bit was clear in status and set in the mask before that write. The interrupt then stays high until it is acknowledged.
- R5: A status write whose bits are all either already set or disabled in the mask does not raise the interrupt. The written bits still appear in status, whatever the mask holds.
- R6: A host write to location 0 clears every status bit written as one and leaves the other bits unchanged. A host read of location 0 returns the full status. When a host clear and a sequencer set hit the same bit in the same cycle, the bit stays set.
- R7: A host write of any data to location 3 clears the interrupt. If a qualifying sequencer write (as in R4) arrives in the same cycle, the interrupt stays high.
- R8: The command word is 16 bits wide. A host write to location 2 ORs the low 16 data bits into it, and a host read of location 2 returns it zero-extended. A sequencer write to location 4 clears the command bits written as one, and a sequencer read of location 4 returns the word. When a host set and a sequencer clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_we | input | 1 | Sequencer write strobe |
| seq_addr | input | 3 | Sequencer location: 0/1 status low/high, 2/3 mask low/high, 4 command |
| seq_wdata | input | 16 | Sequencer write data |
| seq_rdata | output | 16 | Sequencer read data for seq_addr (combinational, zero for unused locations) |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host location: 0 status, 1 mask, 2 command, 3 acknowledge |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational, zero at location 3) |
| irq | output | 1 | Interrupt level |

## Verification
Wrong internal state is visible at the ports within one clock. A corrupted status or mask bit appears on the next read of its location. A wrong new-bit qualification shows on irq in the cycle after the write, either as a missing rise or as a spurious one. The bench compares irq and both read ports against a behavioural model on every cycle, so a divergence is reported in the cycle it first appears. The directed cases cover the re-write of an already set bit, writes to masked bits, and same-cycle set/clear and ack/set collisions. These are the places where a wrong priority would first show.

// File: rtl/mac_event_irq_pkg.sv
package mac_event_irq_pkg;
    // Sequencer register locations
    typedef enum logic [2:0] {
        SEQ_STAT_LO = 3'd0,
        SEQ_STAT_HI = 3'd1,
        SEQ_MASK_LO = 3'd2,
        SEQ_MASK_HI = 3'd3,
        SEQ_CMD     = 3'd4
    } seq_loc_e;

    // Host register locations
    typedef enum logic [1:0] {
        HOST_STAT = 2'd0,
        HOST_MASK = 2'd1,
        HOST_CMD  = 2'd2,
        HOST_ACK  = 2'd3
    } host_loc_e;
endpackage

// File: rtl/irq_status_bank.sv
// Status register with set-wins-over-clear update and a pending flag that
// records the arrival of newly set, enabled bits.
// Assumes set_bits/clr_bits are already decoded single-cycle strobes.
module irq_status_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] mask,
    input  logic         ack,
    output logic [W-1:0] status,
    output logic         pending
);
    logic [W-1:0] fresh;

    // Bits turning on now that are enabled
    always_comb fresh = set_bits & ~status & mask;

    // Status update: clear first, then set so that set wins
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_bits) | set_bits;
    end

    // Pending flag: a fresh event beats an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (|fresh)   pending <= 1'b1;
        else if (ack)      pending <= 1'b0;
    end

    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(set_bits)) == $past(set_bits)));
    a_r6_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ($past(clr_bits) & ~$past(set_bits))) == '0));
    a_r4_new_bit_raises: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_bits & ~status & mask) != '0) |=> pending);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && ((set_bits & ~status & mask) == '0)) |=> !pending);
    a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ((set_bits & ~status & mask) == '0)) |=> !pending);
endmodule

// File: rtl/irq_mask_bank.sv
// Enable mask written in halves by the sequencer or whole by the host.
// Assumes W is even; the host write takes priority over any half write.
module irq_mask_bank #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     half_we,
    input  logic [W/2-1:0] half_data,
    input  logic           full_we,
    input  logic [W-1:0]   full_data,
    output logic [W-1:0]   mask
);
    localparam int HW = W / 2;

    for (genvar h = 0; h < 2; h++) begin : g_half
        // One mask half: host write, else sequencer half write, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)          mask[h*HW +: HW] <= '0;
            else if (full_we)    mask[h*HW +: HW] <= full_data[h*HW +: HW];
            else if (half_we[h]) mask[h*HW +: HW] <= half_data;
        end
    end

    a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && half_we == 2'b00) |=> $stable(mask));
    a_r3_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        full_we |=> (mask == $past(full_data)));
endmodule

// File: rtl/irq_cmd_bank.sv
// Command word: host sets bits, sequencer clears bits written as one.
// Assumes a same-cycle set and clear of a bit should leave it set.
module irq_cmd_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] cmd
);
    // Command update with host set applied after sequencer clear
    always_ff @(posedge clk) begin
        if (!rst_n) cmd <= '0;
        else        cmd <= (cmd & ~clr_bits) | set_bits;
    end

    a_r8_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cmd & ($past(clr_bits) & ~$past(set_bits))) == '0));
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cmd & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/mac_event_irq.sv
// Top of the event interrupt controller: decodes sequencer (16-bit) and
// host (32-bit) accesses onto the status, mask and command banks.
// Assumes single-cycle write strobes and combinational reads.
module mac_event_irq
    import mac_event_irq_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int CMD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_we,
    input  logic [2:0]        seq_addr,
    input  logic [STAT_W/2-1:0] seq_wdata,
    output logic [STAT_W/2-1:0] seq_rdata,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [STAT_W-1:0] host_wdata,
    output logic [STAT_W-1:0] host_rdata,
    output logic              irq
);
    localparam int HW = STAT_W / 2;

    logic [STAT_W-1:0] stat_set, stat_clr, status, mask;
    logic [CMD_W-1:0]  cmd_set, cmd_clr, cmd;
    logic [1:0]        mask_half_we;
    logic              mask_full_we, ack, pending;

    // Sequencer write decode
    always_comb begin
        stat_set     = '0;
        mask_half_we = 2'b00;
        cmd_clr      = '0;
        if (seq_we) begin
            case (seq_loc_e'(seq_addr))
                SEQ_STAT_LO: stat_set[HW-1:0]      = seq_wdata;
                SEQ_STAT_HI: stat_set[STAT_W-1:HW] = seq_wdata;
                SEQ_MASK_LO: mask_half_we[0]       = 1'b1;
                SEQ_MASK_HI: mask_half_we[1]       = 1'b1;
                SEQ_CMD:     cmd_clr               = seq_wdata[CMD_W-1:0];
                default: ;
            endcase
        end
    end

    // Host write decode
    always_comb begin
        stat_clr     = '0;
        mask_full_we = 1'b0;
        cmd_set      = '0;
        ack          = 1'b0;
        if (host_we) begin
            case (host_loc_e'(host_addr))
                HOST_STAT: stat_clr     = host_wdata;
                HOST_MASK: mask_full_we = 1'b1;
                HOST_CMD:  cmd_set      = host_wdata[CMD_W-1:0];
                HOST_ACK:  ack          = 1'b1;
                default: ;
            endcase
        end
    end

    irq_status_bank #(.W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_bits(stat_set), .clr_bits(stat_clr),
        .mask(mask), .ack(ack), .status(status), .pending(pending)
    );

    irq_mask_bank #(.W(STAT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .half_we(mask_half_we), .half_data(seq_wdata),
        .full_we(mask_full_we), .full_data(host_wdata), .mask(mask)
    );

    irq_cmd_bank #(.W(CMD_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .set_bits(cmd_set), .clr_bits(cmd_clr), .cmd(cmd)
    );

    // Sequencer read mux
    always_comb begin
        seq_rdata = '0;
        case (seq_loc_e'(seq_addr))
            SEQ_STAT_LO: seq_rdata = status[HW-1:0];
            SEQ_STAT_HI: seq_rdata = status[STAT_W-1:HW];
            SEQ_MASK_LO: seq_rdata = mask[HW-1:0];
            SEQ_MASK_HI: seq_rdata = mask[STAT_W-1:HW];
            SEQ_CMD:     seq_rdata[CMD_W-1:0] = cmd;
            default: ;
        endcase
    end

    // Host read mux
    always_comb begin
        host_rdata = '0;
        case (host_loc_e'(host_addr))
            HOST_STAT: host_rdata = status;
            HOST_MASK: host_rdata = mask;
            HOST_CMD:  host_rdata[CMD_W-1:0] = cmd;
            default: ;
        endcase
    end

    assign irq = pending;

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq && status == '0 && mask == '0 && cmd == '0));
endmodule

// File: tb/mac_event_irq_test.sv
module mac_event_irq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seq_we = 1'b0;
    logic [2:0]  seq_addr = '0;
    logic [15:0] seq_wdata = '0;
    logic [15:0] seq_rdata;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    logic [31:0] m_stat = '0, m_mask = '0;
    logic [15:0] m_cmd = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    mac_event_irq uut (
        .clk(clk), .rst_n(rst_n), .seq_we(seq_we), .seq_addr(seq_addr),
        .seq_wdata(seq_wdata), .seq_rdata(seq_rdata), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq)
    );

    function automatic logic [15:0] m_seq_read(input logic [2:0] a);
        case (a)
            3'd0: return m_stat[15:0];
            3'd1: return m_stat[31:16];
            3'd2: return m_mask[15:0];
            3'd3: return m_mask[31:16];
            3'd4: return m_cmd;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_host_read(input logic [1:0] a);
        case (a)
            2'd0: return m_stat;
            2'd1: return m_mask;
            2'd2: return {16'h0, m_cmd};
            default: return 32'h0;
        endcase
    endfunction

    task automatic compare(input string req);
        checks++;
        if (irq !== m_irq) begin
            fails++;
            $display("FAIL %s irq actual=%0b expected=%0b", req, irq, m_irq);
        end
        checks++;
        if (seq_rdata !== m_seq_read(seq_addr)) begin
            fails++;
            $display("FAIL %s seq_rdata[%0d] actual=%h expected=%h", req, seq_addr,
                     seq_rdata, m_seq_read(seq_addr));
        end
        checks++;
        if (host_rdata !== m_host_read(host_addr)) begin
            fails++;
            $display("FAIL %s host_rdata[%0d] actual=%h expected=%h", req, host_addr,
                     host_rdata, m_host_read(host_addr));
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic cyc(input string req, input bit swe, input logic [2:0] sa,
                       input logic [15:0] sd, input bit hwe, input logic [1:0] ha,
                       input logic [31:0] hd);
        logic [31:0] sset, hclr, newm;
        logic [15:0] sclr, hset;
        bit ack;
        seq_we = swe; seq_addr = sa; seq_wdata = sd;
        host_we = hwe; host_addr = ha; host_wdata = hd;
        @(posedge clk);
        sset = '0; hclr = '0; sclr = '0; hset = '0; ack = 0; newm = m_mask;
        if (swe && sa == 3'd0) sset = {16'h0, sd};
        if (swe && sa == 3'd1) sset = {sd, 16'h0};
        if (swe && sa == 3'd2) newm[15:0] = sd;
        if (swe && sa == 3'd3) newm[31:16] = sd;
        if (swe && sa == 3'd4) sclr = sd;
        if (hwe && ha == 2'd0) hclr = hd;
        if (hwe && ha == 2'd1) newm = hd;
        if (hwe && ha == 2'd2) hset = hd[15:0];
        if (hwe && ha == 2'd3) ack = 1;
        if (rst_n) begin
            m_irq  = ((sset & ~m_stat & m_mask) != 0) ? 1'b1 : (ack ? 1'b0 : m_irq);
            m_stat = (m_stat & ~hclr) | sset;
            m_mask = newm;
            m_cmd  = (m_cmd & ~sclr) | hset;
        end
        @(negedge clk);
        seq_we = 0; host_we = 0;
        compare(req);
    endtask

    task automatic rd(input string req, input logic [2:0] sa, input logic [1:0] ha);
        cyc(req, 0, sa, 16'h0, 0, ha, 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rd("R1", 3'd0, 2'd0);
        rd("R1", 3'd2, 2'd1);
        rst_n = 1'b1;
        rd("R1", 3'd4, 2'd2);
        // R5: mask zero, status accumulates, no irq
        cyc("R5", 1, 3'd0, 16'h0003, 0, 2'd0, 0);
        cyc("R2", 1, 3'd1, 16'h0100, 0, 2'd0, 0);
        rd("R2", 3'd1, 2'd0);
        // R3: mask halves from sequencer, full from host
        cyc("R3", 1, 3'd3, 16'h8000, 0, 2'd1, 0);
        cyc("R3", 1, 3'd2, 16'h0001, 0, 2'd1, 0);
        rd("R3", 3'd3, 2'd1);
        // R5: rewriting an already set enabled bit does not fire
        cyc("R5", 1, 3'd0, 16'h0001, 0, 2'd0, 0);
        // R6: W1C clears bit 0 only
        cyc("R6", 0, 3'd0, 0, 1, 2'd0, 32'h0000_0001);
        // R4: bit 0 now clear and enabled
        cyc("R4", 1, 3'd0, 16'h0001, 0, 2'd0, 0);
        rd("R4", 3'd0, 2'd0);
        // R7: ack drops irq
        cyc("R7", 0, 3'd0, 0, 1, 2'd3, 0);
        // R5: masked new bit accumulates without irq
        cyc("R5", 1, 3'd0, 16'h0010, 0, 2'd0, 0);
        // R4: high half enabled bit 31
        cyc("R4", 1, 3'd1, 16'h8000, 0, 2'd0, 0);
        // R7: ack with simultaneous qualifying set keeps irq
        cyc("R6", 0, 3'd0, 0, 1, 2'd0, 32'h0000_0001);
        cyc("R7", 1, 3'd0, 16'h0001, 1, 2'd3, 0);
        cyc("R7", 0, 3'd0, 0, 1, 2'd3, 0);
        // R6: same-cycle clear and set of bit 0, set wins
        cyc("R6", 1, 3'd0, 16'h0001, 1, 2'd0, 32'h0000_0001);
        // R3: host and sequencer write mask together, host wins
        cyc("R3", 1, 3'd2, 16'hFFFF, 1, 2'd1, 32'h0000_0F00);
        rd("R3", 3'd2, 2'd1);
        // R8: command set by host, cleared by sequencer
        cyc("R8", 0, 3'd4, 0, 1, 2'd2, 32'hFFFF_0003);
        cyc("R8", 1, 3'd4, 16'h0001, 0, 2'd2, 0);
        cyc("R8", 1, 3'd4, 16'h0002, 1, 2'd2, 32'h0000_0002);
        rd("R8", 3'd4, 2'd2);
        // R6: full clear, then R1 reset again
        cyc("R6", 0, 3'd0, 0, 1, 2'd0, 32'hFFFF_FFFF);
        cyc("R1", 1, 3'd0, 16'h0F00, 0, 2'd0, 0);
        rst_n = 1'b0;
        m_stat = '0; m_mask = '0; m_cmd = '0; m_irq = 0;
        rd("R1", 3'd0, 2'd0);
        rst_n = 1'b1;
        rd("R1", 3'd4, 2'd1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule